// File: doc/BRIEF.md
# Multi-Master I2C Byte Engine with Arbitration-Loss Demotion

The block moves one I2C byte at a time on an open-drain bus that other masters may share. It pulls SCL and SDA low through two enable outputs and reads back the wired-AND bus levels. As master transmitter it makes the SCL pulses and shifts a byte out, most significant bit first. A ninth clock follows, with SDA left free for the acknowledge. At every rising SCL edge of a data bit it checks the bus SDA level against the level it is driving.

If it is driving a 1 and the bus shows a 0, another master has won. The block then records the loss, drops its master and transmit bits, and lets go of both lines. It goes on counting bus clocks as a receiver until the ninth edge has passed. It then raises a pending flag and holds SCL low until software services it.

A small register port with four addresses gives access to the block. It offers a clock half-period register, a control register, a data buffer and a status register. Reading or writing the data buffer, or writing the control register, clears the loss flag. A two-write unlock triggers a soft reset of the transfer logic. Start and stop conditions, address matching and the processor bus lie outside the block.

Top module: `i2c_arb_xfer`

## Requirements
- R1: The register map is address 0 half-period (reset 4), address 1 control, address 2 data, and address 3 status. Control has bit7 master, bit6 transmit, bit5 pending (read-only), bits[3:2] mode and bits[1:0] reset key (reads 0). Status has bit0 lost and bit1 busy. After reset both enables are 0, control reads 0, status reads 0 and the half-period reads 4.
- R2: With master and transmit set, a data write starts a byte. The 8 data bits go out MSB first, and SDA is pulled low only for 0 bits. On the ninth (acknowledge) clock SDA is released, and `sda_oe_o` is only ever 1 while transmitting a byte.
- R3: At each of the 8 data-bit rising edges of bus SCL, the block sets status bit0 if it drives 1 and bus SDA is 0. If the bus always matches, bit0 stays 0.
- R4: In the same cycle that the loss flag rises, control bit7 and bit6 are cleared (slave receiver).
- R5: From the losing edge to the end of the byte, `scl_oe_o` and `sda_oe_o` stay 0.
- R6: A byte ends after 9 bus SCL rising edges, whether or not arbitration was lost. At the next SCL fall, pending (control bit5) is set and `scl_oe_o` holds SCL low. The data register then holds the 8 bus SDA samples, MSB first.
- R7: A data write, a data read (`rd_en_i` at address 2) or a control write clears the loss flag. A data write or data read also clears pending and frees SCL. A data write starts a byte only while the master bit is 1.
- R8: A control write with key 10, followed by a control write with key 01, is a soft reset. It clears master, transmit, pending and busy, and frees both lines. The mode field keeps its earlier value (not the value in the key-01 write), and the half-period register is kept.
- R9: After a key-10 write, any control write with a key other than 01 disarms the unlock, so a following key-01 write has no reset effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects at address 2) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on `addr_i` |
| scl_bus_i | input | 1 | SCL level on the bus, synchronous to `clk_i` |
| sda_bus_i | input | 1 | SDA level on the bus, synchronous to `clk_i` |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
A second bus master in the bench sends its own byte at the same time and runs a slower clock that synchronises with the block's. The sweep covers 256 pairs of transmitted and competing bytes. When the competitor's byte is numerically smaller, the block must lose at the first differing bit, end up holding the competitor's byte, and stay silent on both lines from that edge on. When the competitor's byte is equal or larger, the block must win, and the bus samples must equal its own byte. Further directed sequences test each flag-clearing access, the slave-mode data write that must not start a byte, a soft reset in the middle of a byte, and a key sequence broken by a key-00 write.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [1:0] {
    REG_HALF = 2'd0,
    REG_CTRL = 2'd1,
    REG_DATA = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_MST     = 7;
  localparam int unsigned CTL_TRX     = 6;
  localparam int unsigned CTL_PEND    = 5;
  localparam int unsigned CTL_MODE_HI = 3;
  localparam int unsigned CTL_MODE_LO = 2;
  localparam int unsigned ST_LOST     = 0;
  localparam int unsigned ST_BUSY     = 1;

  localparam logic [1:0] KEY_ARM  = 2'b10;
  localparam logic [1:0] KEY_FIRE = 2'b01;
endpackage

// File: rtl/i2c_arb_regs.sv
module i2c_arb_regs
  import i2c_arb_pkg::*;
#(
  parameter int unsigned REG_W    = 8,
  parameter int unsigned HALF_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             busy_i,
  input  logic             al_set_i,
  input  logic             byte_done_i,
  input  logic [REG_W-1:0] rx_i,
  output logic [REG_W-1:0] half_o,
  output logic             mst_o,
  output logic             trx_o,
  output logic             pend_o,
  output logic             al_o,
  output logic             start_o,
  output logic             soft_rst_o
);
  logic       wr_half, wr_ctrl, wr_data, rd_data;
  logic       key_armed;
  logic [1:0] mode_q;

  assign wr_half = wr_en_i && (addr_i == REG_HALF);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign wr_data = wr_en_i && (addr_i == REG_DATA);
  assign rd_data = rd_en_i && (addr_i == REG_DATA);

  assign soft_rst_o = wr_ctrl && key_armed && (wdata_i[1:0] == KEY_FIRE);
  assign start_o    = wr_data && mst_o && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_o    <= REG_W'(HALF_RST);
      mst_o     <= 1'b0;
      trx_o     <= 1'b0;
      pend_o    <= 1'b0;
      al_o      <= 1'b0;
      mode_q    <= '0;
      key_armed <= 1'b0;
    end else begin
      if (wr_half) half_o <= wdata_i;
      if (wr_ctrl) key_armed <= (wdata_i[1:0] == KEY_ARM);
      if (wr_ctrl && !soft_rst_o) begin
        mst_o  <= wdata_i[CTL_MST];
        trx_o  <= wdata_i[CTL_TRX];
        mode_q <= wdata_i[CTL_MODE_HI:CTL_MODE_LO];
      end
      if (wr_data || rd_data) pend_o <= 1'b0;
      if (wr_data || rd_data || wr_ctrl) al_o <= 1'b0;
      if (byte_done_i) pend_o <= 1'b1;
      if (al_set_i) begin
        al_o  <= 1'b1;
        mst_o <= 1'b0;
        trx_o <= 1'b0;
      end
      if (soft_rst_o) begin
        mst_o  <= 1'b0;
        trx_o  <= 1'b0;
        pend_o <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_HALF: rdata_o = half_o;
      REG_CTRL: begin
        rdata_o[CTL_MST]  = mst_o;
        rdata_o[CTL_TRX]  = trx_o;
        rdata_o[CTL_PEND] = pend_o;
        rdata_o[CTL_MODE_HI:CTL_MODE_LO] = mode_q;
      end
      REG_DATA: rdata_o = rx_i;
      default: begin
        rdata_o[ST_LOST] = al_o;
        rdata_o[ST_BUSY] = busy_i;
      end
    endcase
  end

  AST_KEY_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && (wdata_i[1:0] != KEY_ARM)) |=> !key_armed) // R9
    else $error("key unlock not disarmed");
endmodule

// File: rtl/i2c_arb_sclgen.sv
module i2c_arb_sclgen #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              hold_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              scl_bus_i,
  input  logic              scl_fall_i,
  output logic              pull_o
);
  logic              low_q;
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] lim;

  assign lim    = (half_i == '0) ? '0 : half_i - HALF_W'(1);
  assign pull_o = run_i && low_q;

  // low phase counted from own pull; high phase counted only while the bus is high;
  // a bus fall during the high phase restarts the low phase (clock sync)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (clr_i || !run_i) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (low_q) begin
      if (!hold_i) begin
        if (cnt_q >= lim) begin
          low_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + HALF_W'(1);
        end
      end
    end else if (scl_fall_i) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (scl_bus_i) begin
      if (cnt_q >= lim) begin
        low_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  AST_HOLD_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i && low_q && !clr_i) |=> (low_q || !run_i)) // R6
    else $error("clock released after last edge");
endmodule

// File: rtl/i2c_arb_bitengine.sv
module i2c_arb_bitengine #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic [BITS-1:0] tx_i,
  input  logic            trx_i,
  input  logic            scl_bus_i,
  input  logic            sda_bus_i,
  output logic            busy_o,
  output logic            scl_fall_o,
  output logic            last_o,
  output logic            sda_pull_o,
  output logic            al_set_o,
  output logic            byte_done_o,
  output logic [BITS-1:0] rx_o
);
  localparam int unsigned CW = $clog2(BITS + 2);
  localparam logic [CW-1:0] LAST = CW'(BITS + 1);
  localparam logic [CW-1:0] NDAT = CW'(BITS);

  logic [CW-1:0]   rise_cnt, drv_idx;
  logic [BITS-1:0] tx_q;
  logic            scl_q, rise, data_ph, drv_bit;

  assign rise       = scl_bus_i && !scl_q;
  assign scl_fall_o = !scl_bus_i && scl_q;
  assign data_ph    = rise_cnt < NDAT;
  assign drv_bit    = (drv_idx < NDAT) ? tx_q[BITS-1] : 1'b1;
  assign last_o     = rise_cnt == LAST;

  assign sda_pull_o  = busy_o && trx_i && !drv_bit;
  assign al_set_o    = busy_o && trx_i && rise && data_ph && drv_bit && !sda_bus_i;
  assign byte_done_o = busy_o && scl_fall_o && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q    <= 1'b1;
      busy_o   <= 1'b0;
      rise_cnt <= '0;
      drv_idx  <= '0;
      tx_q     <= '0;
      rx_o     <= '0;
    end else begin
      scl_q <= scl_bus_i;
      if (clr_i) begin
        busy_o   <= 1'b0;
        rise_cnt <= '0;
        drv_idx  <= '0;
      end else if (start_i) begin
        busy_o   <= 1'b1;
        rise_cnt <= '0;
        drv_idx  <= '0;
        tx_q     <= tx_i;
      end else if (busy_o) begin
        // counting continues after a loss so the byte end is still found
        if (rise && !last_o) begin
          rise_cnt <= rise_cnt + CW'(1);
          if (data_ph) rx_o <= {rx_o[BITS-2:0], sda_bus_i};
        end
        if (scl_fall_o) begin
          if (drv_idx != rise_cnt) tx_q <= {tx_q[BITS-2:0], 1'b0};
          drv_idx <= rise_cnt;
          if (last_o) busy_o <= 1'b0;
        end
      end
    end
  end

  AST_RISE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt <= LAST) // R6
    else $error("edge count overrun");
  AST_DRV_TRAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (drv_idx == rise_cnt || drv_idx + CW'(1) == rise_cnt)) // R2
    else $error("drive index out of step");
endmodule

// File: rtl/i2c_arb_xfer.sv
module i2c_arb_xfer
  import i2c_arb_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned HALF_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              scl_bus_i,
  input  logic              sda_bus_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic [BYTE_W-1:0] half, rx;
  logic mst, trx, pend, al, start, soft_rst;
  logic busy, scl_fall, last, sda_pull, al_set, byte_done, pull;

  i2c_arb_regs #(.REG_W(BYTE_W), .HALF_RST(HALF_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .al_set_i(al_set), .byte_done_i(byte_done), .rx_i(rx),
    .half_o(half), .mst_o(mst), .trx_o(trx), .pend_o(pend), .al_o(al),
    .start_o(start), .soft_rst_o(soft_rst)
  );

  i2c_arb_bitengine #(.BITS(BYTE_W)) u_eng (
    .clk_i, .rst_ni, .clr_i(soft_rst), .start_i(start), .tx_i(wdata_i),
    .trx_i(trx), .scl_bus_i, .sda_bus_i, .busy_o(busy), .scl_fall_o(scl_fall),
    .last_o(last), .sda_pull_o(sda_pull), .al_set_o(al_set),
    .byte_done_o(byte_done), .rx_o(rx)
  );

  i2c_arb_sclgen #(.HALF_W(BYTE_W)) u_scl (
    .clk_i, .rst_ni, .clr_i(soft_rst), .run_i(busy && mst), .hold_i(last),
    .half_i(half), .scl_bus_i, .scl_fall_i(scl_fall), .pull_o(pull)
  );

  assign scl_oe_o = pull || pend;
  assign sda_oe_o = sda_pull;

  AST_AL_DEMOTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(al) |-> (!mst && !trx)) // R4
    else $error("loss without demotion");
  AST_QUIET_AFTER_AL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al && busy) |-> (!scl_oe_o && !sda_oe_o)) // R5
    else $error("line driven after loss");
  AST_DONE_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !wr_en_i && !rd_en_i) |=> (pend && scl_oe_o)) // R6
    else $error("byte end did not hold clock");
  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (!mst && !trx && !pend && !busy && !scl_oe_o && !sda_oe_o)) // R8
    else $error("soft reset incomplete");
  AST_SDA_ONLY_WHEN_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (trx && busy)) // R2
    else $error("data line driven outside transmit");
endmodule

// File: tb/sim_i2c_arb_xfer.sv
module sim_i2c_arb_xfer;
  localparam int OH = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       scl_oe, sda_oe, scl_bus, sda_bus;
  logic       o_scl_low, o_sda_low;

  int n_run = 0, n_fail = 0;

  // second master state
  logic       o_start = 1'b0, mon_clr = 1'b0;
  logic [7:0] ob_r = 8'd0;
  logic       o_act = 1'b0, o_low = 1'b0, tscl_q = 1'b1;
  int         o_cnt = 0, o_rise = 0, o_idx = 0;
  logic [7:0] cap = 8'd0;
  logic       ack_hi = 1'b0, viol = 1'b0;
  int         mon_rise = 0, p_exp = 99;
  logic       t_rise, t_fall;

  assign scl_bus   = ~(scl_oe | o_scl_low);
  assign sda_bus   = ~(sda_oe | o_sda_low);
  assign o_scl_low = o_act & o_low;
  assign o_sda_low = o_act & (o_idx < 8) & ~ob_r[3'(7 - o_idx)];
  assign t_rise    = scl_bus & ~tscl_q;
  assign t_fall    = ~scl_bus & tscl_q;

  i2c_arb_xfer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .scl_bus_i(scl_bus), .sda_bus_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  always @(posedge clk) begin
    tscl_q <= scl_bus;
    if (mon_clr) begin
      mon_rise <= 0; cap <= 8'd0; ack_hi <= 1'b0; viol <= 1'b0;
    end else begin
      if (t_rise) begin
        mon_rise <= mon_rise + 1;
        if (mon_rise < 8) cap <= {cap[6:0], sda_bus};
        if (mon_rise == 8) ack_hi <= sda_bus;
      end
      if (mon_rise > p_exp && mon_rise < 9 && (scl_oe || sda_oe)) viol <= 1'b1;
    end
    if (o_start) begin
      o_act <= 1'b1; o_low <= 1'b1; o_cnt <= 0; o_rise <= 0; o_idx <= 0;
    end else if (o_act) begin
      if (o_low) begin
        if (o_cnt >= OH - 1) begin o_low <= 1'b0; o_cnt <= 0; end
        else o_cnt <= o_cnt + 1;
      end else if (t_fall) begin
        o_low <= 1'b1; o_cnt <= 0;
      end else if (scl_bus) begin
        if (o_cnt >= OH - 1) begin o_low <= 1'b1; o_cnt <= 0; end
        else o_cnt <= o_cnt + 1;
      end
      if (t_rise) begin
        o_rise <= o_rise + 1;
        if (o_rise < 8 && ob_r[3'(7 - o_idx)] && !sda_bus) o_act <= 1'b0;
      end
      if (t_fall) begin
        o_idx <= o_rise;
        if (o_rise == 9) o_act <= 1'b0;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic rd_pop();
    @(negedge clk); addr = 2'd2; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic start_byte(input logic [7:0] tx, input logic [7:0] ob, input bit act);
    @(negedge clk);
    addr = 2'd2; wdata = tx; wr_en = 1'b1; ob_r = ob; o_start = act; mon_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; o_start = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_pend(input string tag);
    bit got = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); addr = 2'd1; #1;
      if (rdata[5]) begin got = 1'b1; break; end
    end
    chk(got, tag, int'(got), 1);
  endtask

  function automatic int first_diff(input logic [7:0] a, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) if (a[k] != b[k]) return 7 - k;
    return 99;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, tx, ob;
    bit lost_exp, prev_lost;
    prev_lost = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    peek(2'd0, v); chk(v == 8'd4, "R1 half reset", v, 4);
    peek(2'd1, v); chk(v == 8'd0, "R1 ctrl reset", v, 0);
    peek(2'd3, v); chk(v == 8'd0, "R1 status reset", v, 0);
    chk(!scl_oe && !sda_oe, "R1 lines free", {scl_oe, sda_oe}, 0);

    // sweep: own byte vs competing byte
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        tx = 8'((i * 37 + 5) & 255);
        ob = (j == 0) ? tx : 8'((j * 53 + 11) & 255);
        lost_exp = (ob < tx);
        wr(2'd1, 8'hC0);
        if (prev_lost) begin
          peek(2'd3, v); chk(v[0] == 1'b0, "R7 control write clears lost", v[0], 0);
        end
        p_exp = lost_exp ? first_diff(tx, ob) : 99;
        start_byte(tx, ob, 1'b1);
        wait_pend("R6 pending after byte");
        repeat (20) @(negedge clk);
        peek(2'd3, v); chk(v[0] == lost_exp, "R3 lost flag", v[0], lost_exp);
        peek(2'd1, v);
        chk(v[7:6] == (lost_exp ? 2'b00 : 2'b11), "R4 mode after byte", v[7:6],
            lost_exp ? 0 : 3);
        chk(scl_oe && !scl_bus, "R6 clock held low", {scl_oe, scl_bus}, 2);
        peek(2'd2, v);
        chk(v == (lost_exp ? ob : tx), "R6 received byte", v, lost_exp ? ob : tx);
        if (!lost_exp) begin
          chk(cap == tx, "R2 bus bits msb first", cap, tx);
          chk(ack_hi, "R2 ack bit released", ack_hi, 1);
        end else begin
          chk(!viol, "R5 silent after loss", viol, 0);
        end
        prev_lost = lost_exp;
      end
    end

    // R7 data read clears
    wr(2'd1, 8'hC0);
    p_exp = 0;
    start_byte(8'h80, 8'h00, 1'b1);
    wait_pend("R6 pending before read");
    peek(2'd3, v); chk(v[0], "R3 loss at msb", v[0], 1);
    rd_pop();
    peek(2'd3, v); chk(v[0] == 1'b0, "R7 data read clears lost", v[0], 0);
    peek(2'd1, v); chk(v[5] == 1'b0, "R7 data read clears pending", v[5], 0);
    chk(!scl_oe, "R7 clock freed after read", scl_oe, 0);

    // R7 data write clears, no start in slave mode
    wr(2'd1, 8'hC0);
    start_byte(8'h80, 8'h00, 1'b1);
    wait_pend("R6 pending before write");
    p_exp = 99;
    start_byte(8'h55, 8'h00, 1'b0);
    repeat (5) @(negedge clk);
    peek(2'd3, v); chk(v == 8'd0, "R7 data write clears lost, no start", v, 0);
    peek(2'd1, v); chk(v[5] == 1'b0, "R7 data write clears pending", v[5], 0);
    chk(!scl_oe && !sda_oe, "R7 lines free after slave write", {scl_oe, sda_oe}, 0);

    // R8 soft reset mid-byte
    wr(2'd0, 8'd5);
    wr(2'd1, 8'hC8);
    start_byte(8'hA5, 8'h00, 1'b0);
    repeat (30) @(negedge clk);
    peek(2'd3, v); chk(v[1], "R8 busy before reset", v[1], 1);
    wr(2'd1, 8'hCA);
    wr(2'd1, 8'hC5);
    repeat (2) @(negedge clk);
    peek(2'd1, v); chk(v == 8'h08, "R8 control after soft reset", v, 8'h08);
    peek(2'd3, v); chk(v[1] == 1'b0, "R8 idle after soft reset", v[1], 0);
    chk(!scl_oe && !sda_oe, "R8 lines freed", {scl_oe, sda_oe}, 0);
    peek(2'd0, v); chk(v == 8'd5, "R8 half kept", v, 5);

    // R9 broken key sequence
    wr(2'd1, 8'hCA);
    wr(2'd1, 8'hC8);
    wr(2'd1, 8'hC5);
    peek(2'd1, v); chk(v == 8'hC4, "R9 no reset after disarm", v, 8'hC4);
    wr(2'd1, 8'hCA);
    wr(2'd1, 8'hC1);
    peek(2'd1, v); chk(v == 8'h08, "R8 reset when idle", v, 8'h08);

    summary();
    $finish;
  end
endmodule